// File: doc/BRIEF.md
# Twelve-Bit Accumulator Processor Core

This block is a compact stored-program processor. It has an accumulator, an operand register, an index register and a latched output port. Code and data share one memory of 256 twelve-bit words. Each instruction word carries a 4-bit major opcode in bits 11:8 and an 8-bit operand address in bits 7:0. Major code 1111 is an escape: bits 7:4 then pick one of sixteen register-only operations, and bits 3:0 carry nothing.

Every instruction uses the same six-cycle phase sequence, so the running time of a program follows from the number of instructions it executes. Execution begins at address 0 after clear is released. A halt instruction stops all state until the next clear. While clear is held, a simple write port fills the memory, so a host or a bench can place a program before it starts.

Top module: `acc12_core`

## Requirements
- R1: While `clr` is high, `port_out` reads 0 and `halted` reads 0. The accumulator, operand, index, program counter and return registers are cleared, and execution starts at address 0 once `clr` falls. A word on `ld_data` is written to address `ld_addr` on a clock edge where both `clr` and `ld_we` are high.
- R2: Every instruction takes exactly six clock cycles. When the halt instruction is the N-th instruction executed after clear, `halted` rises on clock edge 6(N-1)+4 after `clr` falls.
- R3: Memory operations use major codes 0000 (load accumulator from the word at the address field), 0011 (store accumulator), 0100 (load operand register) and 0101 (load index register).
- R4: Major code 0001 adds the operand register to the accumulator and 0010 subtracts it. Both wrap modulo 4096.
- R5: Escape codes (major 1111, bits 7:4) work as follows: 0000 does nothing, 0001 clears the accumulator, 0101 inverts the accumulator, 0110 inverts the operand register, and 0111 / 1000 / 1001 / 1010 / 1011 write the OR / AND / NOR / NAND / XOR of accumulator and operand register to the accumulator. Bits 3:0 have no effect.
- R6: Escape 0010 swaps accumulator and index, 0011 decrements the index and 0100 increments it. All wrap modulo 4096.
- R7: Major 0110 always jumps to the address field. Major 0111 jumps when accumulator bit 11 is set, and 1000 jumps when the accumulator is zero. An untaken branch continues at the next word.
- R8: Major 1001 jumps when index bit 11 is set, and 1010 jumps when the index is zero.
- R9: Major 1011 saves the address of the word after the call in a single return register and jumps. Escape 1100 resumes at the saved address.
- R10: Escape 1101 loads `ext_in` into the accumulator. Escape 1110 copies the accumulator to `port_out`, which holds that value until the next such copy.
- R11: Escape 1111 raises `halted`. After that, `port_out` and `halted` stay unchanged until clear, whatever `ext_in` does.
- R12: The 8-bit program counter wraps from address FF to address 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| clr | input | 1 | Synchronous clear, active high |
| ld_we | input | 1 | Preload write strobe, honoured during clear |
| ld_addr | input | 8 | Preload word address |
| ld_data | input | 12 | Preload word |
| ext_in | input | 12 | External data word read by the input instruction |
| port_out | output | 12 | Latched output port |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The bench aims at edges where a plausible bug stays hidden on common data:
- Sign and zero tests at 0x7FF, 0x800, 0xFFF and 0. A design that tested the wrong bit, or compared against the wrong value, would branch the wrong way and output the other marker word.
- Index increments and decrements across 0xFFF/0x000. These expose a carry that is too narrow.
- A program that falls off address FF. A counter without the wrap would run into filler halts, and the output or the halt cycle would differ.
- The return address after a call. If it were saved before the increment, the call would run twice and the halt would come late.
- The halt cycle of every program is compared. A lost or extra phase, or a branch that takes extra cycles, shifts that edge.

// File: rtl/acc12_pkg.sv
`timescale 1ns/1ps
package acc12_pkg;
   // Major opcode held in the top nibble of the instruction word.
   typedef enum logic [3:0] {
      MJ_LOADA  = 4'h0,
      MJ_ADDB   = 4'h1,
      MJ_SUBB   = 4'h2,
      MJ_STOREA = 4'h3,
      MJ_LOADB  = 4'h4,
      MJ_LOADX  = 4'h5,
      MJ_JUMP   = 4'h6,
      MJ_JNEGA  = 4'h7,
      MJ_JZERA  = 4'h8,
      MJ_JNEGX  = 4'h9,
      MJ_JZERX  = 4'hA,
      MJ_CALL   = 4'hB,
      MJ_SPARE0 = 4'hC,
      MJ_SPARE1 = 4'hD,
      MJ_SPARE2 = 4'hE,
      MJ_ESC    = 4'hF
   } major_e;

   // Register-only operation picked by the second nibble under the escape.
   typedef enum logic [3:0] {
      RX_NOP    = 4'h0,
      RX_CLRA   = 4'h1,
      RX_SWAPAX = 4'h2,
      RX_DECX   = 4'h3,
      RX_INCX   = 4'h4,
      RX_NOTA   = 4'h5,
      RX_NOTB   = 4'h6,
      RX_OR     = 4'h7,
      RX_AND    = 4'h8,
      RX_NOR    = 4'h9,
      RX_NAND   = 4'hA,
      RX_XOR    = 4'hB,
      RX_RET    = 4'hC,
      RX_IN     = 4'hD,
      RX_OUT    = 4'hE,
      RX_HALT   = 4'hF
   } minor_e;

   // Side effects raised by the execute stage in the working phase.
   typedef struct packed {
      logic wr_mem;
      logic wr_out;
      logic halt;
      logic take;
      logic call;
      logic ret;
   } exec_ctl_t;
endpackage

// File: rtl/acc12_ram.sv
`timescale 1ns/1ps
module acc12_ram #(
   parameter int DW = 12,
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [DW-1:0] wd,
   input  logic [AW-1:0] ra,
   output logic [DW-1:0] rd
);
   localparam int DEPTH = 1 << AW;

   if (AW < 1 || AW > 12) begin : g_bad_aw
      $error("acc12_ram: address width out of range");
   end

   logic [DW-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[wa] <= wd;
   end

   assign rd = cells[ra];
endmodule

// File: rtl/acc12_phase.sv
`timescale 1ns/1ps
module acc12_phase #(
   parameter int NPHASE = 6,
   parameter bit ONEHOT = 1'b0,
   parameter int PW     = $clog2(NPHASE)
) (
   input  logic          clk,
   input  logic          clr,
   input  logic          run,
   output logic [PW-1:0] idx
);
   localparam logic [PW-1:0] LAST = PW'(NPHASE - 1);

   if (NPHASE < 4) begin : g_bad_n
      $error("acc12_phase: at least four phases are needed");
   end

   if (ONEHOT) begin : g_ring
      logic [NPHASE-1:0] ring_q;
      always_ff @(posedge clk) begin
         if (clr)      ring_q <= NPHASE'(1);
         else if (run) ring_q <= {ring_q[NPHASE-2:0], ring_q[NPHASE-1]};
      end
      always_comb begin
         idx = '0;
         for (int i = 0; i < NPHASE; i++) begin
            if (ring_q[i]) idx = PW'(i);
         end
      end
   end else begin : g_bin
      logic [PW-1:0] cnt_q;
      always_ff @(posedge clk) begin
         if (clr)      cnt_q <= '0;
         else if (run) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + PW'(1);
      end
      assign idx = cnt_q;
   end
endmodule

// File: rtl/acc12_exec.sv
`timescale 1ns/1ps
module acc12_exec
   import acc12_pkg::*;
#(
   parameter int DW = 12
) (
   input  major_e        major,
   input  minor_e        minor,
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  logic [DW-1:0] x,
   input  logic [DW-1:0] mdr,
   input  logic [DW-1:0] ext_in,
   output logic [DW-1:0] a_n,
   output logic [DW-1:0] b_n,
   output logic [DW-1:0] x_n,
   output exec_ctl_t     ctl
);
   localparam int SB = DW - 1;

   logic a_neg, a_zero, x_neg, x_zero;
   assign a_neg  = a[SB];
   assign a_zero = (a == '0);
   assign x_neg  = x[SB];
   assign x_zero = (x == '0);

   always_comb begin
      a_n = a;
      b_n = b;
      x_n = x;
      ctl = '0;
      case (major)
         MJ_LOADA:  a_n = mdr;
         MJ_ADDB:   a_n = a + b;
         MJ_SUBB:   a_n = a - b;
         MJ_STOREA: ctl.wr_mem = 1'b1;
         MJ_LOADB:  b_n = mdr;
         MJ_LOADX:  x_n = mdr;
         MJ_JUMP:   ctl.take = 1'b1;
         MJ_JNEGA:  ctl.take = a_neg;
         MJ_JZERA:  ctl.take = a_zero;
         MJ_JNEGX:  ctl.take = x_neg;
         MJ_JZERX:  ctl.take = x_zero;
         MJ_CALL: begin
            ctl.take = 1'b1;
            ctl.call = 1'b1;
         end
         MJ_ESC: begin
            case (minor)
               RX_NOP:    ;
               RX_CLRA:   a_n = '0;
               RX_SWAPAX: begin
                  a_n = x;
                  x_n = a;
               end
               RX_DECX:   x_n = x - DW'(1);
               RX_INCX:   x_n = x + DW'(1);
               RX_NOTA:   a_n = ~a;
               RX_NOTB:   b_n = ~b;
               RX_OR:     a_n = a | b;
               RX_AND:    a_n = a & b;
               RX_NOR:    a_n = ~(a | b);
               RX_NAND:   a_n = ~(a & b);
               RX_XOR:    a_n = a ^ b;
               RX_RET:    ctl.ret = 1'b1;
               RX_IN:     a_n = ext_in;
               RX_OUT:    ctl.wr_out = 1'b1;
               RX_HALT:   ctl.halt = 1'b1;
               default:   ;
            endcase
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/acc12_core.sv
`timescale 1ns/1ps
module acc12_core
   import acc12_pkg::*;
#(
   parameter int DW           = 12,
   parameter int AW           = 8,
   parameter int NPHASE       = 6,
   parameter bit PHASE_ONEHOT = 1'b0
) (
   input  logic          clk,
   input  logic          clr,
   input  logic          ld_we,
   input  logic [AW-1:0] ld_addr,
   input  logic [DW-1:0] ld_data,
   input  logic [DW-1:0] ext_in,
   output logic [DW-1:0] port_out,
   output logic          halted
);
   localparam int PW = $clog2(NPHASE);
   localparam logic [PW-1:0] PH_FETCH = PW'(0);
   localparam logic [PW-1:0] PH_INCR  = PW'(1);
   localparam logic [PW-1:0] PH_OPER  = PW'(2);
   localparam logic [PW-1:0] PH_EXEC  = PW'(3);

   if (DW - AW != 4) begin : g_bad_split
      $error("acc12_core: word must be a 4-bit opcode plus the address");
   end
   if (AW < 4) begin : g_bad_aw
      $error("acc12_core: address field must hold the escape selector");
   end

   logic [AW-1:0] pc_q, ret_q;
   logic [DW-1:0] ir_q, mdr_q, a_q, b_q, x_q, o_q;
   logic [PW-1:0] phase;
   logic          run;

   assign run = ~halted;

   acc12_phase #(
      .NPHASE (NPHASE),
      .ONEHOT (PHASE_ONEHOT),
      .PW     (PW)
   ) u_phase (
      .clk (clk),
      .clr (clr),
      .run (run),
      .idx (phase)
   );

   // Memory access: the program counter addresses fetches, the
   // address field addresses operands and stores.
   logic [AW-1:0] rd_addr, wr_addr;
   logic [DW-1:0] rd_data, wr_data;
   logic          wr_en;
   exec_ctl_t     ctl;

   assign rd_addr = (phase == PH_FETCH) ? pc_q : ir_q[AW-1:0];
   assign wr_en   = clr ? ld_we   : (run && phase == PH_EXEC && ctl.wr_mem);
   assign wr_addr = clr ? ld_addr : ir_q[AW-1:0];
   assign wr_data = clr ? ld_data : a_q;

   acc12_ram #(
      .DW (DW),
      .AW (AW)
   ) u_ram (
      .clk (clk),
      .we  (wr_en),
      .wa  (wr_addr),
      .wd  (wr_data),
      .ra  (rd_addr),
      .rd  (rd_data)
   );

   major_e        major;
   minor_e        minor;
   logic [DW-1:0] a_n, b_n, x_n;

   assign major = major_e'(ir_q[DW-1 -: 4]);
   assign minor = minor_e'(ir_q[AW-1 -: 4]);

   acc12_exec #(
      .DW (DW)
   ) u_exec (
      .major  (major),
      .minor  (minor),
      .a      (a_q),
      .b      (b_q),
      .x      (x_q),
      .mdr    (mdr_q),
      .ext_in (ext_in),
      .a_n    (a_n),
      .b_n    (b_n),
      .x_n    (x_n),
      .ctl    (ctl)
   );

   // Next program counter in the working phase: branch target, saved
   // return address, or the already-incremented value.
   logic [AW-1:0] pc_n;
   always_comb begin
      if (ctl.take)     pc_n = ir_q[AW-1:0];
      else if (ctl.ret) pc_n = ret_q;
      else              pc_n = pc_q;
   end

   always_ff @(posedge clk) begin
      if (clr) begin
         pc_q   <= '0;
         ret_q  <= '0;
         ir_q   <= '0;
         mdr_q  <= '0;
         a_q    <= '0;
         b_q    <= '0;
         x_q    <= '0;
         o_q    <= '0;
         halted <= 1'b0;
      end else if (run) begin
         case (phase)
            PH_FETCH: ir_q  <= rd_data;
            PH_INCR:  pc_q  <= pc_q + AW'(1);
            PH_OPER:  mdr_q <= rd_data;
            PH_EXEC: begin
               a_q  <= a_n;
               b_q  <= b_n;
               x_q  <= x_n;
               pc_q <= pc_n;
               if (ctl.call)   ret_q  <= pc_q;
               if (ctl.wr_out) o_q    <= a_q;
               if (ctl.halt)   halted <= 1'b1;
            end
            default: ;
         endcase
      end
   end

   assign port_out = o_q;
endmodule

// File: rtl/acc12_chk.sv
`timescale 1ns/1ps
module acc12_chk #(
   parameter int DW     = 12,
   parameter int AW     = 8,
   parameter int NPHASE = 6
) (
   input logic                      clk,
   input logic                      clr,
   input logic [$clog2(NPHASE)-1:0] phase,
   input logic [AW-1:0]             pc,
   input logic [DW-1:0]             port_out,
   input logic                      halted
);
   localparam int PW = $clog2(NPHASE);
   localparam logic [PW-1:0] LAST = PW'(NPHASE - 1);
   localparam logic [PW-1:0] INCR = PW'(1);
   localparam logic [PW-1:0] EXEC = PW'(3);

   // R2: the phase walks 0..NPHASE-1 and wraps while running
   a_r2_phase_step: assert property (@(posedge clk) disable iff (clr)
      !halted |=> (($past(phase) == LAST) ? (phase == '0)
                                          : (phase == $past(phase) + PW'(1))));

   // R2: a halt only takes effect in the working phase
   a_r2_halt_in_exec: assert property (@(posedge clk) disable iff (clr)
      $rose(halted) |-> ($past(phase) == EXEC));

   // R10: the output port moves only through the working phase
   a_r10_out_held: assert property (@(posedge clk) disable iff (clr)
      (phase != EXEC) |=> $stable(port_out));

   // R11: once halted, nothing moves until clear
   a_r11_frozen: assert property (@(posedge clk) disable iff (clr)
      halted |=> (halted && $stable(port_out) && $stable(pc) && $stable(phase)));

   // R12: the increment phase adds one modulo the address space
   a_r12_pc_step: assert property (@(posedge clk) disable iff (clr)
      (phase == INCR && !halted) |=> (pc == $past(pc) + AW'(1)));
endmodule

bind acc12_core acc12_chk #(
   .DW     (DW),
   .AW     (AW),
   .NPHASE (NPHASE)
) u_chk (
   .clk      (clk),
   .clr      (clr),
   .phase    (phase),
   .pc       (pc_q),
   .port_out (port_out),
   .halted   (halted)
);

// File: tb/sim_acc12_core.sv
`timescale 1ns/1ps
module sim_acc12_core;
   logic        clk = 1'b0;
   logic        clr = 1'b1;
   logic        ld_we = 1'b0;
   logic [7:0]  ld_addr = '0;
   logic [11:0] ld_data = '0;
   logic [11:0] ext_in = '0;
   wire  [11:0] port_out;
   wire         halted;

   always #10 clk = ~clk;

   acc12_core u0 (
      .clk      (clk),
      .clr      (clr),
      .ld_we    (ld_we),
      .ld_addr  (ld_addr),
      .ld_data  (ld_data),
      .ext_in   (ext_in),
      .port_out (port_out),
      .halted   (halted)
   );

   logic [11:0] img [256];
   int n_cmp = 0;
   int n_bad = 0;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic fill();
      for (int i = 0; i < 256; i++) img[i] = 12'hFF0;
   endtask

   function automatic logic [11:0] mr(input logic [3:0] op, input logic [7:0] ad);
      return {op, ad};
   endfunction

   // escape word with a random junk low nibble (R5: ignored)
   function automatic logic [11:0] rx(input logic [3:0] code);
      logic [3:0] junk;
      junk = 4'($urandom_range(15, 0));
      return {4'hF, code, junk};
   endfunction

   // Instruction-level reference: final output port and executed count.
   task automatic model(output logic [11:0] o, output int n);
      logic [11:0] m [256];
      logic [11:0] a, b, x, w;
      logic [7:0]  pc, ret, ad;
      bit          stop;
      for (int i = 0; i < 256; i++) m[i] = img[i];
      a = '0; b = '0; x = '0; o = '0; pc = '0; ret = '0; n = 0; stop = 0;
      while (!stop && n < 3000) begin
         w = m[pc]; pc = pc + 8'd1; n++; ad = w[7:0];
         case (w[11:8])
            4'h0: a = m[ad];
            4'h1: a = a + b;
            4'h2: a = a - b;
            4'h3: m[ad] = a;
            4'h4: b = m[ad];
            4'h5: x = m[ad];
            4'h6: pc = ad;
            4'h7: if (a[11]) pc = ad;
            4'h8: if (a == 0) pc = ad;
            4'h9: if (x[11]) pc = ad;
            4'hA: if (x == 0) pc = ad;
            4'hB: begin ret = pc; pc = ad; end
            4'hF: case (w[7:4])
               4'h1: a = '0;
               4'h2: begin w = a; a = x; x = w; end
               4'h3: x = x - 12'd1;
               4'h4: x = x + 12'd1;
               4'h5: a = ~a;
               4'h6: b = ~b;
               4'h7: a = a | b;
               4'h8: a = a & b;
               4'h9: a = ~(a | b);
               4'hA: a = ~(a & b);
               4'hB: a = a ^ b;
               4'hC: pc = ret;
               4'hD: a = ext_in;
               4'hE: o = a;
               4'hF: stop = 1;
               default: ;
            endcase
            default: ;
         endcase
      end
   endtask

   task automatic run(input string req, input string what);
      logic [11:0] eo, hold;
      int en, cyc;
      model(eo, en);
      @(negedge clk);
      clr = 1'b1;
      for (int i = 0; i < 256; i++) begin
         ld_we = 1'b1; ld_addr = 8'(i); ld_data = img[i];
         @(negedge clk);
      end
      ld_we = 1'b0;
      chk("R1", "port in clear", 32'(port_out), 32'h0);
      chk("R1", "halted in clear", 32'(halted), 32'h0);
      clr = 1'b0;
      cyc = 0;
      while (1) begin
         @(posedge clk);
         cyc++;
         @(negedge clk);
         if (halted) break;
         if (cyc > 20000) break;
      end
      chk("R2", {what, " halt edge"}, 32'(cyc), 32'(6 * (en - 1) + 4));
      chk(req, what, 32'(port_out), 32'(eo));
      hold = port_out;
      ext_in = 12'($urandom);
      repeat (25) @(negedge clk);
      chk("R11", "halt held", 32'(halted), 32'h1);
      chk("R11", "port held", 32'(port_out), 32'(hold));
   endtask

   logic [11:0] corner [6] = '{12'h000, 12'h001, 12'h7FF, 12'h800, 12'hFFF, 12'h5A5};
   logic [3:0]  alu_ops [10] = '{4'h1, 4'h2, 4'h7, 4'h8, 4'h9, 4'hA, 4'hB, 4'h5, 4'h6, 4'h1};

   initial begin
      void'($urandom(32'd2718));

      // R12: wrap past FF, also R7 zero test on cleared A (R1)
      fill();
      img[8'h00] = mr(4'h8, 8'hFD);
      img[8'h01] = rx(4'hF);
      img[8'hFD] = mr(4'h0, 8'h10);
      img[8'hFE] = rx(4'hE);
      img[8'hFF] = rx(4'h0);
      img[8'h10] = 12'h5A5;
      run("R12", "pc wrap");

      // R7 / R8 branches on corner and random values
      for (int c = 0; c < 5; c++) begin
         for (int v = 0; v < 7; v++) begin
            logic [3:0] op;
            op = (c == 0) ? 4'h6 : 4'(c + 6);
            fill();
            img[0] = mr((op >= 4'h9) ? 4'h5 : 4'h0, 8'h80);
            img[1] = mr(op, 8'h05);
            img[2] = mr(4'h0, 8'h81);
            img[3] = rx(4'hE);
            img[4] = rx(4'hF);
            img[5] = mr(4'h0, 8'h82);
            img[6] = rx(4'hE);
            img[7] = rx(4'hF);
            img[8'h80] = (v < 6) ? corner[v] : 12'($urandom);
            img[8'h81] = 12'h111;
            img[8'h82] = 12'h222;
            run((op >= 4'h9) ? "R8" : "R7", "branch");
         end
      end

      // R4 / R5: two-operand and single-register operations
      for (int k = 0; k < 24; k++) begin
         logic [3:0] op;
         op = alu_ops[k % 10];
         fill();
         img[0] = mr(4'h0, 8'h80);
         img[1] = mr(4'h4, 8'h81);
         img[2] = (k % 10 < 2) ? mr(op, 8'h33) : rx(op);
         img[3] = (op == 4'h6) ? mr(4'h1, 8'h00) : rx(4'h0);
         img[4] = rx(4'hE);
         img[5] = rx(4'hF);
         img[8'h80] = (k < 4) ? corner[k + 2] : 12'($urandom);
         img[8'h81] = (k < 4) ? corner[4 - k] : 12'($urandom);
         run((k % 10 < 2) ? "R4" : "R5", "alu op");
      end

      // R6: swap, increment and decrement across the wrap points
      for (int k = 0; k < 6; k++) begin
         fill();
         img[0] = mr(4'h0, 8'h80);
         img[1] = mr(4'h5, 8'h81);
         img[2] = rx(4'h2);
         img[3] = rx((k % 2 == 0) ? 4'h4 : 4'h3);
         img[4] = rx((k % 2 == 0) ? 4'h4 : 4'h3);
         img[5] = rx((k % 2 == 0) ? 4'h3 : 4'h4);
         img[6] = rx(4'h2);
         img[7] = rx(4'hE);
         img[8] = rx(4'hF);
         img[8'h80] = (k < 4) ? ((k < 2) ? 12'hFFF : 12'h000) : 12'($urandom);
         img[8'h81] = 12'($urandom);
         run("R6", "index ops");
      end

      // R6 / R8: count the index down in a loop, adding B each pass
      for (int k = 0; k < 3; k++) begin
         fill();
         img[0] = mr(4'h5, 8'h80);
         img[1] = mr(4'h4, 8'h81);
         img[2] = mr(4'h1, 8'h00);
         img[3] = rx(4'h3);
         img[4] = mr(4'hA, 8'h06);
         img[5] = mr(4'h6, 8'h02);
         img[6] = rx(4'hE);
         img[7] = rx(4'hF);
         img[8'h80] = 12'($urandom_range(9, 1));
         img[8'h81] = 12'($urandom);
         run("R8", "countdown loop");
      end

      // R9: call and return, from two call sites
      for (int k = 0; k < 2; k++) begin
         fill();
         img[0] = mr(4'h0, 8'h80);
         img[1] = mr(4'hB, 8'h40);
         img[2] = mr(4'hB, 8'h40);
         img[3] = rx(4'hE);
         img[4] = rx(4'hF);
         img[8'h40] = mr(4'h4, 8'h81);
         img[8'h41] = mr(4'h1, 8'h00);
         img[8'h42] = rx(4'hC);
         img[8'h80] = 12'($urandom);
         img[8'h81] = 12'($urandom);
         run("R9", "call return");
      end

      // R3: store then reload through the operand register
      for (int k = 0; k < 3; k++) begin
         fill();
         img[0] = mr(4'h0, 8'h80);
         img[1] = mr(4'h3, 8'h90);
         img[2] = rx(4'h1);
         img[3] = mr(4'h4, 8'h90);
         img[4] = mr(4'h1, 8'h00);
         img[5] = rx(4'hE);
         img[6] = rx(4'hF);
         img[8'h80] = 12'($urandom);
         img[8'h90] = 12'h000;
         run("R3", "store reload");
      end

      // R10: input word reaches the port, held after A is cleared
      for (int k = 0; k < 3; k++) begin
         fill();
         img[0] = rx(4'hD);
         img[1] = rx(4'hE);
         img[2] = rx(4'h1);
         img[3] = rx(4'hF);
         ext_in = 12'($urandom);
         run("R10", "input to port");
      end

      // R3..R6 mixed: random straight-line programs
      for (int k = 0; k < 10; k++) begin
         fill();
         for (int i = 0; i < 14; i++) begin
            int r;
            r = $urandom_range(19, 0);
            if (r < 6) img[i] = mr(4'(r), 8'(8'h80 + $urandom_range(7, 0)));
            else if (r < 18) img[i] = rx(4'(r - 6));
            else img[i] = rx((r == 18) ? 4'hD : 4'hE);
         end
         img[14] = rx((k % 2 == 0) ? 4'h2 : 4'h0);
         img[15] = rx(4'hE);
         img[16] = rx(4'hF);
         for (int i = 0; i < 8; i++) img[8'h80 + i] = 12'($urandom);
         ext_in = 12'($urandom);
         run("R3", "random program");
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #3500000;
      n_bad++;
      $display("FAIL R2 watchdog: actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule